// File: doc/BRIEF.md
# Sectioned Register Access Controller

This block sits between a two-wire bus byte decoder and a 64-address control register space. The decoder hands it start and stop pulses plus a stream of received bytes (device select, register address, write data) and read slots. For every byte the block answers acknowledge or not-acknowledge. It tracks the register pointer, and it decides whether a transaction stops early. Bit-level bus timing is not handled here.

The space holds five sections: two 8-byte alarm sections at 0x00 and 0x08, a 1-byte control register at 0x10, an 8-byte clock section at 0x30 and a 1-byte status register at 0x3F. Bursts stay inside the section they started in and wrap to its first byte. Write data is gathered in a buffer and is released to the register file only by a stop that ends a clean write. The protected sections (all except status) also need an unlock state. That state is built by two successive status writes. Received bytes arrive on a valid/ready stream. The block drops ready only while it plays a committed buffer out to the register write port, one section slot per cycle.

Top module: `regspace_access`

## Requirements
- R1: A byte taken right after a start is acknowledged only if its upper seven bits are 1101111. Bit 0 set selects a read and clear selects a write. Any other value is not acknowledged, and the rest of that transaction then gets neither acknowledge nor abort.
- R2: In a write, the byte after the device select is the register address. Addresses 0x00-0x10, 0x30-0x37 and 0x3F are acknowledged and load the pointer. Any other value is not acknowledged, raises abort and leaves the pointer unchanged.
- R3: Each write data byte or read slot uses the pointer and then advances it. The pointer wraps from the last byte of its section back to the first: 0x07→0x00, 0x0F→0x08, 0x37→0x30. The 1-byte sections stay put.
- R4: In the status register (0x3F), a second data byte or a second read slot in the same transaction is not acknowledged and raises abort. Any buffered write data of that transaction is then discarded.
- R5: A buffered write to a protected section (anything other than 0x3F) reaches the write port only if the unlock output is high when the stop arrives.
- R6: Buffered data is committed only by a stop that ends the write transaction. A repeated start or an abort discards it.
- R7: A committed status write sets the enable state from its bit 1 (arm) and bit 2 (unlock). A value of 01 in bits [2:1] gives arm=1, unlock=0. A value of 11 while arm is already 1 gives arm=1, unlock=1. Every other case clears both bits.
- R8: A read slot outputs the pointer on rd_addr with rd_en. A read that starts without an address byte continues from the pointer left by the previous transaction, which is the last accessed address plus one within its section.
- R9: A commit holds in_ready low for exactly 8 cycles. During that time it issues one write per buffered slot in ascending address order. A slot written twice in the burst carries the last value.
- R10: After reset the arm and unlock outputs are 0, in_ready is 1, and no response, read or write is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen on the bus (one-cycle pulse) |
| in_valid | input | 1 | Received byte or read slot offered |
| in_ready | output | 1 | Block can take a byte; low while a commit plays out |
| in_data | input | 8 | Received byte (ignored for read slots) |
| rsp_valid | output | 1 | Response for the byte taken in the previous cycle |
| rsp_ack | output | 1 | Acknowledge for that byte |
| rsp_abort | output | 1 | Transaction terminated by that byte |
| rd_en | output | 1 | Read slot served this response |
| rd_addr | output | 6 | Register selected for the read |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 6 | Register written |
| wr_data | output | 8 | Value written |
| wr_arm | output | 1 | First-step write enable state |
| wr_unlock | output | 1 | Second-step write enable state |

## Verification
The assertions take for granted that start, stop and byte handshakes never fall in the same cycle, and that no start or stop pulse arrives while in_ready is low. Under those assumptions a commit can only follow a stop, and its base address cannot shift while it plays out. The bench drives one event per task. It moves on only after in_ready has returned high, and it lowers in_valid after each handshake, so every response it samples belongs to exactly one byte.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int SEC_MAX = 8;
  localparam int OFF_W   = $clog2(SEC_MAX);
  localparam logic [6:0] DEV_ID = 7'b1101111;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(8'h3F);
  localparam int ARM_BIT    = 1;
  localparam int UNLOCK_BIT = 2;

  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_ADDR, PH_WDATA, PH_RDATA} phase_e;

  typedef struct packed {
    logic              hit;
    logic              prot;
    logic [ADDR_W-1:0] base;
    logic [OFF_W-1:0]  mask;
  } sec_t;

  // Section map: where each register group lives and how far a burst may run.
  function automatic sec_t sec_lookup(input logic [DATA_W-1:0] a);
    sec_t s;
    s = '0;
    if (a < 8'h08) begin
      s.hit = 1'b1; s.prot = 1'b1; s.base = ADDR_W'(8'h00); s.mask = '1;
    end else if (a < 8'h10) begin
      s.hit = 1'b1; s.prot = 1'b1; s.base = ADDR_W'(8'h08); s.mask = '1;
    end else if (a == 8'h10) begin
      s.hit = 1'b1; s.prot = 1'b1; s.base = ADDR_W'(8'h10); s.mask = '0;
    end else if (a >= 8'h30 && a < 8'h38) begin
      s.hit = 1'b1; s.prot = 1'b1; s.base = ADDR_W'(8'h30); s.mask = '1;
    end else if (a == 8'h3F) begin
      s.hit = 1'b1; s.prot = 1'b0; s.base = STATUS_ADDR; s.mask = '0;
    end
    return s;
  endfunction
endpackage

// File: rtl/regacc_secmap.sv
module regacc_secmap
  import regacc_pkg::*;
(
  input  logic [DATA_W-1:0] addr,
  output sec_t              sec,
  output logic [ADDR_W-1:0] next_addr
);
  logic [OFF_W-1:0] off_inc;

  always_comb begin
    sec       = sec_lookup(addr);
    off_inc   = (addr[OFF_W-1:0] + OFF_W'(1)) & sec.mask;
    next_addr = sec.base | ADDR_W'(off_inc);
  end
endmodule

// File: rtl/regacc_wbuf.sv
module regacc_wbuf
  import regacc_pkg::*;
#(
  parameter  int DEPTH = SEC_MAX,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              put,
  input  logic [IW-1:0]     put_off,
  input  logic [DATA_W-1:0] put_data,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  output logic              draining,
  output logic              any,
  output logic              out_en,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [IW-1:0]     idx_q;
  logic              drain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      idx_q   <= '0;
      drain_q <= 1'b0;
    end else if (drain_q) begin
      idx_q <= idx_q + IW'(1);
      if (idx_q == IW'(DEPTH-1)) begin
        drain_q <= 1'b0;
        vld_q   <= '0;
        idx_q   <= '0;
      end
    end else if (go) begin
      drain_q <= 1'b1;
    end else if (clr) begin
      vld_q <= '0;
    end else if (put) begin
      vld_q[put_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (put && !drain_q) mem_q[put_off] <= put_data;
  end

  assign draining = drain_q;
  assign any      = |vld_q;
  assign out_en   = drain_q & vld_q[idx_q];
  assign out_addr = base | ADDR_W'(idx_q);
  assign out_data = mem_q[idx_q];
endmodule

// File: rtl/regacc_enlatch.sv
module regacc_enlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic req_arm,
  input  logic req_unlock,
  output logic arm,
  output logic unlock
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm    <= 1'b0;
      unlock <= 1'b0;
    end else if (upd) begin
      if (req_arm && !req_unlock) begin
        arm    <= 1'b1;
        unlock <= 1'b0;
      end else if (req_arm && req_unlock && arm) begin
        arm    <= 1'b1;
        unlock <= 1'b1;
      end else begin
        arm    <= 1'b0;
        unlock <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regspace_access.sv
module regspace_access
  import regacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              rsp_valid,
  output logic              rsp_ack,
  output logic              rsp_abort,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_arm,
  output logic              wr_unlock
);
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              first_q, first_d;
  logic              rv_d, ack_d, ab_d, rd_d;
  logic              put, clr, go;
  logic              hs, at_status, buf_any, draining;
  sec_t              sec_p;
  logic [ADDR_W-1:0] ptr_next;

  regacc_secmap u_map (
    .addr      ({{(DATA_W-ADDR_W){1'b0}}, ptr_q}),
    .sec       (sec_p),
    .next_addr (ptr_next)
  );

  assign hs        = in_valid & in_ready;
  assign at_status = sec_p.hit & ~sec_p.prot;
  assign in_ready  = ~draining;

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    rv_d    = 1'b0;
    ack_d   = 1'b0;
    ab_d    = 1'b0;
    rd_d    = 1'b0;
    put     = 1'b0;
    clr     = 1'b0;
    go      = 1'b0;
    if (ev_start) begin
      phase_d = PH_DEV;
      first_d = 1'b0;
      clr     = 1'b1;
    end else if (ev_stop) begin
      if (phase_q == PH_WDATA && buf_any && (!sec_p.prot || wr_unlock)) go = 1'b1;
      else clr = 1'b1;
      phase_d = PH_IDLE;
    end else if (hs) begin
      rv_d = 1'b1;
      case (phase_q)
        PH_DEV: begin
          if (in_data[DATA_W-1:1] == DEV_ID) begin
            ack_d   = 1'b1;
            phase_d = in_data[0] ? PH_RDATA : PH_ADDR;
          end else begin
            phase_d = PH_IDLE;
          end
        end
        PH_ADDR: begin
          if (sec_lookup(in_data).hit) begin
            ack_d   = 1'b1;
            ptr_d   = in_data[ADDR_W-1:0];
            phase_d = PH_WDATA;
          end else begin
            ab_d    = 1'b1;
            phase_d = PH_IDLE;
          end
        end
        PH_WDATA: begin
          if (at_status && first_q) begin
            ab_d    = 1'b1;
            clr     = 1'b1;
            phase_d = PH_IDLE;
          end else begin
            ack_d   = 1'b1;
            put     = 1'b1;
            ptr_d   = ptr_next;
            first_d = 1'b1;
          end
        end
        PH_RDATA: begin
          if (at_status && first_q) begin
            ab_d    = 1'b1;
            phase_d = PH_IDLE;
          end else begin
            ack_d   = 1'b1;
            rd_d    = 1'b1;
            ptr_d   = ptr_next;
            first_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      ptr_q     <= '0;
      first_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_abort <= 1'b0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
    end else begin
      phase_q   <= phase_d;
      ptr_q     <= ptr_d;
      first_q   <= first_d;
      rsp_valid <= rv_d;
      rsp_ack   <= ack_d;
      rsp_abort <= ab_d;
      rd_en     <= rd_d;
      if (rd_d) rd_addr <= ptr_q;
    end
  end

  regacc_wbuf #(.DEPTH(SEC_MAX)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .put      (put),
    .put_off  (ptr_q[OFF_W-1:0] & sec_p.mask),
    .put_data (in_data),
    .go       (go),
    .base     (sec_p.base),
    .draining (draining),
    .any      (buf_any),
    .out_en   (wr_en),
    .out_addr (wr_addr),
    .out_data (wr_data)
  );

  regacc_enlatch u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (wr_en && wr_addr == STATUS_ADDR),
    .req_arm    (wr_data[ARM_BIT]),
    .req_unlock (wr_data[UNLOCK_BIT]),
    .arm        (wr_arm),
    .unlock     (wr_unlock)
  );
endmodule

// File: rtl/regacc_checker.sv
module regacc_checker
  import regacc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_stop,
  input logic              in_valid,
  input logic              in_ready,
  input logic              rsp_valid,
  input logic              rsp_ack,
  input logic              rsp_abort,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_arm,
  input logic              wr_unlock
);
  a_r4_abort_is_nack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |-> (rsp_valid && !rsp_ack));

  a_r1_rsp_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(in_valid && in_ready));

  a_r5_protected_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != STATUS_ADDR) |-> wr_unlock);

  a_r7_unlock_implies_arm: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unlock |-> wr_arm);

  a_r7_unlock_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_unlock) |-> $past(wr_arm));

  a_r6_commit_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(ev_stop));

  a_r8_read_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> sec_lookup({{(DATA_W-ADDR_W){1'b0}}, rd_addr}).hit);
endmodule

bind regspace_access regacc_checker i_chk (.*);

// File: tb/test_regspace_access.sv
`timescale 1ns/1ps
module test_regspace_access;
  logic       clk = 1'b0;
  logic       rst_n, ev_start, ev_stop, in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       rsp_valid, rsp_ack, rsp_abort, rd_en, wr_en, wr_arm, wr_unlock;
  logic [5:0] rd_addr, wr_addr;
  logic [7:0] wr_data;

  regspace_access i_regspace_access (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] obs  [64];
  logic [7:0] expm [64];
  int exp_ptr = 0;
  bit exp_arm = 0;
  bit exp_unl = 0;

  always @(posedge clk) if (wr_en) obs[wr_addr] <= wr_data;

  function automatic bit sdef(input int a);
    return (a < 17) || (a >= 48 && a < 56) || (a == 63);
  endfunction
  function automatic int sbase(input int a);
    return (a < 8) ? 0 : (a < 16) ? 8 : (a == 16) ? 16 : (a == 63) ? 63 : 48;
  endfunction
  function automatic int smask(input int a);
    return (a == 16 || a == 63) ? 0 : 7;
  endfunction
  function automatic int snext(input int p);
    return sbase(p) | ((p + 1) & smask(p));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_start;
    ev_start = 1'b1;
    @(negedge clk);
    ev_start = 1'b0;
  endtask

  task automatic do_stop(output int busy);
    ev_stop = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0;
    busy = 0;
    while (!in_ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  // write burst of n bytes starting at address a, with model update
  task automatic wr_txn(input int a, input int n, input int seed);
    int  p, busy;
    bit  commit;
    logic [7:0] d;
    commit = sdef(a) && n > 0 && (a == 63 || exp_unl) && !(a == 63 && n > 1);
    do_start;
    beat(8'hDE);
    beat(8'(a));
    chk("R2 addr ack", rsp_ack, sdef(a));
    p = a;
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + 37 * i);
      beat(d);
      if (a == 63 && i > 0) begin
        chk("R4 status extra byte ack", rsp_ack, 0);
        chk("R4 status extra byte abort", rsp_abort, 1);
        break;
      end
      chk("R3 data ack", rsp_ack, 1);
      if (commit) begin
        expm[p] = d;
        if (p == 63) begin
          if (d[2:1] == 2'b01) begin exp_arm = 1; exp_unl = 0; end
          else if (d[2:1] == 2'b11 && exp_arm) begin exp_arm = 1; exp_unl = 1; end
          else begin exp_arm = 0; exp_unl = 0; end
        end
      end
      p = snext(p);
    end
    exp_ptr = p;
    do_stop(busy);
    chk("R9 commit busy cycles", busy, commit ? 8 : 0);
    for (int k = 0; k < 8; k++)
      chk("R3 R5 section contents", int'(obs[sbase(a) | k]), int'(expm[sbase(a) | k]));
    chk("R7 arm", wr_arm, exp_arm);
    chk("R7 unlock", wr_unlock, exp_unl);
  endtask

  task automatic rd_txn(input bit set_addr, input int a, input int n);
    int busy;
    if (set_addr) begin
      do_start;
      beat(8'hDE);
      beat(8'(a));
      exp_ptr = a;
    end
    do_start;
    beat(8'hDF);
    chk("R1 read select ack", rsp_ack, 1);
    for (int i = 0; i < n; i++) begin
      beat(8'h00);
      if (exp_ptr == 63 && i > 0) begin
        chk("R4 status extra read abort", rsp_abort, 1);
        chk("R4 status extra read ack", rsp_ack, 0);
        break;
      end
      chk("R8 read enable", rd_en, 1);
      chk("R8 R3 read address", rd_addr, exp_ptr);
      exp_ptr = snext(exp_ptr);
    end
    do_stop(busy);
    chk("R8 read causes no commit", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual 0 expected 1");
    errors++;
    checks++;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int busy;
    for (int i = 0; i < 64; i++) begin obs[i] = 8'h00; expm[i] = 8'h00; end
    rst_n = 1'b0; ev_start = 1'b0; ev_stop = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 in_ready", in_ready, 1);
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 rd_en", rd_en, 0);
    chk("R10 wr_en", wr_en, 0);
    chk("R10 arm", wr_arm, 0);
    chk("R10 unlock", wr_unlock, 0);

    // R1: every device-select value
    for (int v = 0; v < 128; v++) begin
      do_start;
      beat({7'(v), 1'b0});
      chk("R1 select ack", rsp_ack, v == 7'h6F);
      chk("R1 select response", rsp_valid, 1);
      if (v != 7'h6F) begin
        beat(8'h05);
        chk("R1 ignored ack", rsp_ack, 0);
        chk("R1 ignored abort", rsp_abort, 0);
      end
      do_stop(busy);
    end

    // R2: every address byte, pointer checked by a current-address read
    for (int a = 0; a < 256; a++) begin
      do_start;
      beat(8'hDE);
      beat(8'(a));
      chk("R2 address ack", rsp_ack, sdef(a));
      chk("R2 address abort", rsp_abort, !sdef(a));
      if (sdef(a)) exp_ptr = a;
      do_stop(busy);
      chk("R6 no commit without data", busy, 0);
      rd_txn(0, 0, 1);
    end

    // R7: two-step enable sequence
    wr_txn(63, 1, 8'h02);
    wr_txn(63, 1, 8'h06);
    wr_txn(63, 1, 8'h06);
    wr_txn(63, 1, 8'h00);
    wr_txn(63, 1, 8'h06);
    wr_txn(63, 1, 8'h02);
    wr_txn(63, 1, 8'h04);
    wr_txn(63, 1, 8'h02);
    wr_txn(63, 1, 8'h02);

    // R5: protected writes dropped while locked (arm only)
    wr_txn(8'h00, 4, 8'h11);
    wr_txn(8'h30, 3, 8'h21);
    wr_txn(8'h10, 1, 8'h31);
    wr_txn(63, 1, 8'h00);
    wr_txn(8'h0A, 2, 8'h41);

    // unlock, then sweep every section, start offset and burst length
    wr_txn(63, 1, 8'h02);
    wr_txn(63, 1, 8'h06);
    for (int s = 0; s < 4; s++) begin
      int b;
      b = (s == 0) ? 0 : (s == 1) ? 8 : (s == 2) ? 16 : 48;
      for (int off = 0; off <= smask(b); off++)
        for (int n = 1; n <= 10; n++)
          wr_txn(b + off, n, b * 5 + off * 11 + n * 3 + 1);
    end

    // R4: status burst write aborts and is discarded
    wr_txn(63, 2, 8'h00);
    chk("R4 enable kept after aborted status write", wr_unlock, 1);
    rd_txn(1, 63, 2);

    // R6: repeated start discards buffered data
    do_start;
    beat(8'hDE);
    beat(8'h33);
    beat(8'hAA);
    beat(8'hBB);
    do_start;
    do_stop(busy);
    chk("R6 repeated start discards", busy, 0);
    chk("R6 register untouched", obs[8'h33], expm[8'h33]);
    chk("R6 register untouched", obs[8'h34], expm[8'h34]);

    // R8: read burst wraps and a current-address read continues
    rd_txn(1, 8'h0D, 12);
    rd_txn(0, 0, 3);
    rd_txn(1, 8'h35, 9);
    rd_txn(1, 8'h10, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule